// File: doc/BRIEF.md
# HDLC Receive FIFO and Interrupt Status

This block sits between the bit-level HDLC receiver and transmitter and the host. It stores received bytes in a 128-entry FIFO. Each entry carries an end-of-packet tag. The host pops bytes through a byte-wide read port that shows the head entry at all times.

Around the FIFO the block watches a set of conditions and records each one in a clear-on-read status register:

- receive fill level crossing a programmable full threshold;
- overflow;
- tagged bytes entering the FIFO;
- tagged bytes arriving at the head;
- reads from an empty FIFO;
- the external transmit FIFO level dropping under a programmable low threshold;
- transmit packet completion;
- one shared bit that reports either a received frame abort or a transmit underrun, chosen by `irq_sel`.

A masked OR of the status drives the interrupt line.

A write into a full FIFO is lost. It also shuts the receiver off through a two-state gate:

- `RX_ON` goes to `RX_BLOCKED` on overflow.
- `RX_BLOCKED` goes back to `RX_ON` when the receiver reports a flag.

While the gate is in `RX_BLOCKED`, `rx_disable` is high and every write is ignored.

Top module: `hdlc_fifo_status`

## Requirements
- R1: After reset the status register is zero, the FIFO is empty (`rx_level` 0, `rx_rd_data` 0, `rx_rd_eop` 0), `rx_disable` is low and `irq` is low; status bit 7 is always 0.
- R2: The FIFO holds up to 128 bytes. `rx_rd_data` and `rx_rd_eop` show the oldest entry while the FIFO is non-empty and show zero when it is empty. A pulse on `rx_rd_en` removes the head. Bytes leave in write order, and `rx_level` gives the current fill.
- R3: A write while the gate is `RX_ON` and `rx_level` is 128 is dropped and sets status bit 1 (overflow). From the next cycle the gate is `RX_BLOCKED` and `rx_disable` is high.
- R4: In `RX_BLOCKED`, writes change neither the FIFO nor the status. A cycle with `rx_flag_seen` high returns the gate to `RX_ON` (`rx_disable` low) from the next cycle.
- R5: Status bit 0 is set in the cycle after `rx_level` changes from not above `full_thresh` to above it.
- R6: Status bit 2 is set in the cycle after an accepted write with `rx_wr_eop` high.
- R7: Status bit 3 is set one cycle after a new entry reaches the head with its tag set. A new entry reaches the head when a pop leaves the FIFO non-empty, or when a write lands in an empty FIFO. Bit 3 is also set in the cycle after `rx_rd_en` is pulsed while the FIFO is empty.
- R8: Status bit 4 is set in the cycle after `tx_level < low_thresh` becomes true. The condition counts as already true at reset, so an idle transmitter raises nothing.
- R9: Status bit 5 is set in the cycle after a `tx_eop_done` pulse.
- R10: Status bit 6 is set in the cycle after `rx_abort` when `irq_sel` is 0, or after `tx_underrun` when `irq_sel` is 1. The unselected source has no effect.
- R11: A cycle with `stat_rd` high clears every status bit. A bit whose event occurs in that same cycle is set afterwards. `stat_q` always shows the register contents.
- R12: `irq` is high exactly when some status bit is set and the matching `irq_mask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_wr_en | input | 1 | Receiver byte write strobe |
| rx_wr_data | input | 8 | Received byte |
| rx_wr_eop | input | 1 | Byte ends a packet |
| rx_flag_seen | input | 1 | Receiver detected a flag |
| rx_abort | input | 1 | Received frame abort pulse |
| rx_rd_en | input | 1 | Host pop of FIFO head |
| rx_rd_data | output | 8 | Head byte |
| rx_rd_eop | output | 1 | Head byte tag |
| rx_level | output | 8 | FIFO fill level |
| rx_disable | output | 1 | Receiver forced off after overflow |
| full_thresh | input | 8 | Receive full threshold |
| tx_level | input | 8 | Transmit FIFO fill level |
| low_thresh | input | 8 | Transmit low threshold |
| tx_eop_done | input | 1 | Transmit packet finished or aborted |
| tx_underrun | input | 1 | Transmitter read an empty transmit FIFO |
| irq_sel | input | 1 | Selects the source of status bit 6 |
| stat_rd | input | 1 | Host status read (clears status) |
| irq_mask | input | 8 | Per-bit interrupt enable |
| stat_q | output | 8 | Status register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is overflow followed by the blocked state. To get there, the bench writes 128 bytes with no reads and then keeps writing. It then checks three things: the lost byte, the writes ignored afterwards, and the return to `RX_ON` on a flag pulse. It finishes by draining all 128 entries in order. A second hard corner is the look-ahead bit when single-byte packets follow each other. There the head tag stays high across a pop, so only the head-change event can set the bit. The bench covers this with back-to-back tagged bytes, and also with a status read issued in the same cycle as a new event.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;

    localparam int SW = 8;

    // status bit positions
    localparam int B_RXFULL = 0;
    localparam int B_OVF    = 1;
    localparam int B_EOPW   = 2;
    localparam int B_EOPR   = 3;
    localparam int B_TXLOW  = 4;
    localparam int B_TXEOP  = 5;
    localparam int B_ABT    = 6;

    typedef enum logic {
        RX_ON      = 1'b0,
        RX_BLOCKED = 1'b1
    } rx_gate_e;

endpackage

// File: rtl/hdlc_rx_gate.sv
module hdlc_rx_gate
    import hdlc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_ev,
    input  logic flag_seen,
    output logic rx_on,
    output logic rx_disable
);

    rx_gate_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            RX_ON:      if (ovf_ev)    st_nxt = RX_BLOCKED;
            RX_BLOCKED: if (flag_seen) st_nxt = RX_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_ON;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            RX_ON:      begin rx_on = 1'b1; rx_disable = 1'b0; end
            RX_BLOCKED: begin rx_on = 1'b0; rx_disable = 1'b1; end
        endcase
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_eop,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          head_eop,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          head_new
);

    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {push_eop, push_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            head_new <= 1'b0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            unique case ({push, pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
            // a different entry sits at the head next cycle
            head_new <= pop || (push && empty);
        end
    end

    always_comb begin
        if (empty) begin
            head_data = '0;
            head_eop  = 1'b0;
        end else begin
            head_data = mem[rd_ptr][DW-1:0];
            head_eop  = mem[rd_ptr][DW];
        end
    end

endmodule

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] ev,
    input  logic          clr,
    input  logic [SW-1:0] mask,
    output logic [SW-1:0] stat,
    output logic          irq
);

    always_ff @(posedge clk) begin
        if (!rst_n)   stat <= '0;
        else if (clr) stat <= ev;
        else          stat <= stat | ev;
    end

    assign irq = |(stat & mask);

endmodule

// File: rtl/hdlc_fifo_status.sv
module hdlc_fifo_status
    import hdlc_stat_pkg::*;
#(
    parameter  int DEPTH = 128,
    parameter  int TXW   = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_wr_en,
    input  logic [7:0]     rx_wr_data,
    input  logic           rx_wr_eop,
    input  logic           rx_flag_seen,
    input  logic           rx_abort,
    input  logic           rx_rd_en,
    output logic [7:0]     rx_rd_data,
    output logic           rx_rd_eop,
    output logic [CW-1:0]  rx_level,
    output logic           rx_disable,
    input  logic [CW-1:0]  full_thresh,
    input  logic [TXW-1:0] tx_level,
    input  logic [TXW-1:0] low_thresh,
    input  logic           tx_eop_done,
    input  logic           tx_underrun,
    input  logic           irq_sel,
    input  logic           stat_rd,
    input  logic [SW-1:0]  irq_mask,
    output logic [SW-1:0]  stat_q,
    output logic           irq
);

    logic rx_on, full, empty, head_new;
    logic push, pop, ovf_ev;
    logic full_cond, full_prev, low_cond, low_prev;
    logic [SW-1:0] ev;

    assign push   = rx_wr_en && rx_on && !full;
    assign ovf_ev = rx_wr_en && rx_on && full;
    assign pop    = rx_rd_en && !empty;

    hdlc_rx_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_ev     (ovf_ev),
        .flag_seen  (rx_flag_seen),
        .rx_on      (rx_on),
        .rx_disable (rx_disable)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_wr_data),
        .push_eop  (rx_wr_eop),
        .pop       (pop),
        .head_data (rx_rd_data),
        .head_eop  (rx_rd_eop),
        .level     (rx_level),
        .full      (full),
        .empty     (empty),
        .head_new  (head_new)
    );

    assign full_cond = rx_level > full_thresh;
    assign low_cond  = tx_level < low_thresh;

    // level history for edge detection; transmit side starts "low"
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_prev <= 1'b0;
            low_prev  <= 1'b1;
        end else begin
            full_prev <= full_cond;
            low_prev  <= low_cond;
        end
    end

    always_comb begin
        ev           = '0;
        ev[B_RXFULL] = full_cond && !full_prev;
        ev[B_OVF]    = ovf_ev;
        ev[B_EOPW]   = push && rx_wr_eop;
        ev[B_EOPR]   = (head_new && !empty && rx_rd_eop) || (rx_rd_en && empty);
        ev[B_TXLOW]  = low_cond && !low_prev;
        ev[B_TXEOP]  = tx_eop_done;
        ev[B_ABT]    = irq_sel ? tx_underrun : rx_abort;
    end

    hdlc_stat_reg #(.SW(SW)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .clr   (stat_rd),
        .mask  (irq_mask),
        .stat  (stat_q),
        .irq   (irq)
    );

endmodule

// File: rtl/hdlc_fifo_status_chk.sv
module hdlc_fifo_status_chk
    import hdlc_stat_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_wr_en,
    input logic          rx_wr_eop,
    input logic          rx_flag_seen,
    input logic          rx_abort,
    input logic          rx_rd_en,
    input logic [CW-1:0] rx_level,
    input logic          rx_disable,
    input logic          tx_eop_done,
    input logic          tx_underrun,
    input logic          irq_sel,
    input logic [SW-1:0] stat_q
);

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr_en && !rx_disable && rx_level == CW'(DEPTH)) |=> (rx_disable && stat_q[B_OVF]));

    p_blocked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_disable && rx_wr_en && !rx_rd_en) |=> $stable(rx_level));

    p_flag_reenable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_disable && rx_flag_seen) |=> !rx_disable);

    p_eop_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr_en && rx_wr_eop && !rx_disable && rx_level < CW'(DEPTH)) |=> stat_q[B_EOPW]);

    p_tx_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eop_done |=> stat_q[B_TXEOP]);

    p_underrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel && tx_underrun) |=> stat_q[B_ABT]);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_sel && rx_abort) |=> stat_q[B_ABT]);

endmodule

bind hdlc_fifo_status hdlc_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_wr_en     (rx_wr_en),
    .rx_wr_eop    (rx_wr_eop),
    .rx_flag_seen (rx_flag_seen),
    .rx_abort     (rx_abort),
    .rx_rd_en     (rx_rd_en),
    .rx_level     (rx_level),
    .rx_disable   (rx_disable),
    .tx_eop_done  (tx_eop_done),
    .tx_underrun  (tx_underrun),
    .irq_sel      (irq_sel),
    .stat_q       (stat_q)
);

// File: tb/tb_hdlc_fifo_status.sv
`timescale 1ns/1ps
module tb_hdlc_fifo_status;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_wr_en, rx_wr_eop, rx_flag_seen, rx_abort, rx_rd_en;
    logic [7:0] rx_wr_data, rx_rd_data, rx_level, full_thresh, tx_level, low_thresh;
    logic       rx_rd_eop, rx_disable, tx_eop_done, tx_underrun, irq_sel, stat_rd, irq;
    logic [7:0] irq_mask, stat_q;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #4 clk = ~clk;   // 125 MHz

    hdlc_fifo_status dut (
        .clk(clk), .rst_n(rst_n),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_wr_eop(rx_wr_eop),
        .rx_flag_seen(rx_flag_seen), .rx_abort(rx_abort), .rx_rd_en(rx_rd_en),
        .rx_rd_data(rx_rd_data), .rx_rd_eop(rx_rd_eop), .rx_level(rx_level),
        .rx_disable(rx_disable), .full_thresh(full_thresh), .tx_level(tx_level),
        .low_thresh(low_thresh), .tx_eop_done(tx_eop_done), .tx_underrun(tx_underrun),
        .irq_sel(irq_sel), .stat_rd(stat_rd), .irq_mask(irq_mask),
        .stat_q(stat_q), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [8:0] q[$];
    bit         m_blk, m_full_prev, m_low_prev, m_head_new;
    logic [7:0] m_stat;
    string      bit_req[8] = '{"R5", "R3", "R6", "R7", "R8", "R9", "R10", "R1"};

    always @(posedge clk) begin
        int  cnt;
        bit  wr_ok, ovf, rd_ok, emp, fcond, lcond;
        logic [7:0] ev;
        if (!rst_n) begin
            q.delete();
            m_blk = 0; m_full_prev = 0; m_low_prev = 1; m_head_new = 0; m_stat = '0;
        end else begin
            cnt   = q.size();
            emp   = (cnt == 0);
            wr_ok = rx_wr_en && !m_blk && cnt < DEPTH;
            ovf   = rx_wr_en && !m_blk && cnt == DEPTH;
            rd_ok = rx_rd_en && !emp;
            fcond = cnt > int'(full_thresh);
            lcond = int'(tx_level) < int'(low_thresh);
            ev    = '0;
            ev[0] = fcond && !m_full_prev;
            ev[1] = ovf;
            ev[2] = wr_ok && rx_wr_eop;
            ev[3] = (m_head_new && !emp && q[0][8]) || (rx_rd_en && emp);
            ev[4] = lcond && !m_low_prev;
            ev[5] = tx_eop_done;
            ev[6] = irq_sel ? tx_underrun : rx_abort;
            m_stat      = stat_rd ? ev : (m_stat | ev);
            m_full_prev = fcond;
            m_low_prev  = lcond;
            m_head_new  = rd_ok || (wr_ok && emp);
            if (rd_ok) void'(q.pop_front());
            if (wr_ok) q.push_back({rx_wr_eop, rx_wr_data});
            if (m_blk) begin
                if (rx_flag_seen) m_blk = 0;
            end else if (ovf) m_blk = 1;
        end
    end

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            int exp_d, exp_e;
            exp_d = (q.size() != 0) ? int'(q[0][7:0]) : 0;
            exp_e = (q.size() != 0) ? int'(q[0][8]) : 0;
            chk(int'(rx_level) == q.size(), "R2", "rx_level", rx_level, q.size());
            chk(int'(rx_rd_data) == exp_d, "R2", "rx_rd_data", rx_rd_data, exp_d);
            chk(int'(rx_rd_eop) == exp_e, "R2", "rx_rd_eop", rx_rd_eop, exp_e);
            chk(rx_disable == m_blk, "R3", "rx_disable", rx_disable, m_blk);
            chk(irq == |(m_stat & irq_mask), "R12", "irq", irq, |(m_stat & irq_mask));
            for (int b = 0; b < 8; b++)
                chk(stat_q[b] == m_stat[b], bit_req[b], $sformatf("stat bit %0d", b),
                    stat_q[b], m_stat[b]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(); @(negedge clk); endtask
    task automatic idle(input int n); repeat (n) @(negedge clk); endtask
    task automatic push(input logic [7:0] d, input logic e);
        rx_wr_en = 1; rx_wr_data = d; rx_wr_eop = e; step(); rx_wr_en = 0; rx_wr_eop = 0;
    endtask
    task automatic pop(); rx_rd_en = 1; step(); rx_rd_en = 0; endtask
    task automatic rd_stat(); stat_rd = 1; step(); stat_rd = 0; endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; rx_wr_en = 0; rx_wr_data = 0; rx_wr_eop = 0; rx_flag_seen = 0;
        rx_abort = 0; rx_rd_en = 0; full_thresh = 8'd200; tx_level = 8'd100;
        low_thresh = 8'd16; tx_eop_done = 0; tx_underrun = 0; irq_sel = 0;
        stat_rd = 0; irq_mask = 8'h00;
        idle(3); rst_n = 1; idle(2);

        // R1 reset state
        chk(stat_q == 0, "R1", "stat_q", stat_q, 0);
        chk(irq == 0 && rx_disable == 0, "R1", "irq/rx_disable", {irq, rx_disable}, 0);
        chk(rx_level == 0 && rx_rd_data == 0, "R1", "level/data", rx_level, 0);

        // small packet, then host drains it
        irq_mask = 8'hFF;
        push(8'hA1, 0); push(8'hA2, 0); push(8'hA3, 1); idle(2);
        chk(stat_q[2] == 1, "R6", "eop written bit", stat_q[2], 1);
        rd_stat(); idle(1);
        pop(); pop(); idle(1);
        chk(stat_q[3] == 1, "R7", "eop look-ahead bit", stat_q[3], 1);
        pop(); idle(1); rd_stat();
        pop(); idle(1);   // empty read
        chk(stat_q[3] == 1, "R7", "empty read", stat_q[3], 1);
        rd_stat();

        // back-to-back single-byte packets
        push(8'h11, 1); push(8'h22, 1); idle(2); rd_stat();
        pop(); idle(1);
        chk(stat_q[3] == 1, "R7", "second tagged head", stat_q[3], 1);
        pop(); idle(1); rd_stat();

        // full threshold crossing
        full_thresh = 8'd4;
        for (int i = 0; i < 6; i++) push(8'(i), 0);
        idle(2);
        chk(stat_q[0] == 1, "R5", "full threshold", stat_q[0], 1);
        for (int i = 0; i < 6; i++) pop();
        idle(1); rd_stat();

        // overflow and recovery
        full_thresh = 8'd200;
        for (int i = 0; i < DEPTH; i++) push(8'(i + 3), (i % 16) == 15);
        chk(rx_level == 8'd128, "R2", "full level", rx_level, 128);
        push(8'hEE, 0);
        chk(rx_disable == 1, "R3", "receiver blocked", rx_disable, 1);
        chk(stat_q[1] == 1, "R3", "overflow bit", stat_q[1], 1);
        rd_stat();
        push(8'h55, 1); idle(1);
        chk(rx_level == 8'd128, "R4", "blocked write ignored", rx_level, 128);
        chk(stat_q[2] == 0 && stat_q[1] == 0, "R4", "no status while blocked", stat_q, 0);
        rx_flag_seen = 1; step(); rx_flag_seen = 0;
        chk(rx_disable == 0, "R4", "flag re-enables", rx_disable, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk(rx_rd_data == 8'(i + 3), "R2", "drain order", rx_rd_data, (i + 3) % 256);
            pop();
        end
        idle(2); rd_stat();

        // transmit low threshold
        tx_level = 8'd10; idle(2);
        chk(stat_q[4] == 1, "R8", "tx low", stat_q[4], 1);
        rd_stat(); idle(2);
        chk(stat_q[4] == 0, "R8", "level held, no re-set", stat_q[4], 0);
        tx_level = 8'd40; idle(1); tx_level = 8'd3; idle(2); rd_stat();

        // transmit end of packet, shared bit
        tx_eop_done = 1; step(); tx_eop_done = 0; rd_stat();
        irq_sel = 0;
        tx_underrun = 1; step(); tx_underrun = 0; idle(1);
        chk(stat_q[6] == 0, "R10", "underrun ignored when sel=0", stat_q[6], 0);
        rx_abort = 1; step(); rx_abort = 0; idle(1); rd_stat();
        irq_sel = 1;
        rx_abort = 1; step(); rx_abort = 0; idle(1);
        chk(stat_q[6] == 0, "R10", "abort ignored when sel=1", stat_q[6], 0);
        tx_underrun = 1; step(); tx_underrun = 0; idle(1);
        chk(stat_q[6] == 1, "R10", "underrun when sel=1", stat_q[6], 1);

        // R11: read colliding with event keeps the new event
        tx_eop_done = 1; step(); tx_eop_done = 0; idle(1);
        stat_rd = 1; tx_eop_done = 1; step(); stat_rd = 0; tx_eop_done = 0;
        chk(stat_q == 8'h20, "R11", "read with concurrent event", stat_q, 32);

        // R12 mask
        irq_mask = 8'h10; idle(1);
        chk(irq == 0, "R12", "masked", irq, 0);
        irq_mask = 8'h20; idle(1);
        chk(irq == 1, "R12", "unmasked", irq, 1);
        idle(3);
        finish_run();
    end

endmodule